// File: doc/BRIEF.md
# Per-Thread Deadline Timer Unit

This block gives a multithreaded processor a shared notion of absolute time and lets each hardware thread act on it. A single 64-bit counter counts nanoseconds and moves forward by a fixed step on every clock. A thread can sample that counter. It can also block itself until an absolute timestamp has been reached. Separately, it can arm a deadline that later raises an exception request carrying a handler address, and it can cancel that deadline before it fires.

One operation is issued per cycle. Each operation carries an opcode, the number of the issuing thread, a 64-bit timestamp made from two 32-bit register operands, and a handler address. Every thread owns one wait slot and one deadline slot, so threads never disturb each other. The comparisons use greater-or-equal. Because the counter steps by more than one, it may jump past a deadline value without ever equalling it, and greater-or-equal still catches that case.

Top module: `deadline_timer_unit`

## Requirements
- R1: While rst_n is low, and in the first cycle after release, time_now, rd_data, stall and exc_req are all zero.
- R2: time_now increases by exactly STEP (default 20) on every clock edge after reset is released.
- R3: An operation with op_code 1 (read time) makes rd_data show, from the next cycle on, the time_now value seen in the issue cycle. Other opcodes leave rd_data unchanged.
- R4: An operation with op_code 2 (wait) whose timestamp {ts_hi,ts_lo} is greater than time_now in the issue cycle raises stall[op_tid] from the next cycle. stall stays high until the first cycle in which time_now >= timestamp, and it is low in that cycle.
- R5: A wait whose timestamp is less than or equal to time_now in the issue cycle never raises stall.
- R6: An operation with op_code 3 (arm) records the timestamp and the handler address and never raises stall.
- R7: After an arm, exc_req[t] is high for exactly one cycle. That cycle is the first one, from the cycle after the arm onward, in which time_now >= the armed timestamp. In that cycle, exc_addr[t*32 +: 32] holds the recorded handler.
- R8: Once an armed deadline has fired, that thread raises no further request until it is armed again.
- R9: An operation with op_code 4 (disarm) cancels a pending deadline if it is issued before the firing cycle. A disarm issued in the firing cycle itself does not suppress that cycle's request.
- R10: Arming a thread that is already armed replaces its timestamp and its handler.
- R11: An operation affects only the slot of thread op_tid. Nothing happens when op_valid is low or when op_code is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| op_valid | input | 1 | An operation is issued this cycle |
| op_code | input | 3 | 0 none, 1 read time, 2 wait, 3 arm, 4 disarm |
| op_tid | input | 3 | Issuing thread |
| ts_hi | input | 32 | Upper half of the timestamp |
| ts_lo | input | 32 | Lower half of the timestamp |
| handler | input | 32 | Handler address for arm |
| time_now | output | 64 | Current time in nanoseconds |
| rd_data | output | 64 | Time captured by the last read operation |
| stall | output | 8 | Per-thread stall line |
| exc_req | output | 8 | Per-thread one-cycle deadline exception request |
| exc_addr | output | 256 | Per-thread recorded handler, thread t at bits t*32 +: 32 |

## Verification
Each input change lands in the cycle after its issue edge. rd_data, the rise of stall and the arming of a deadline all take effect there. The release of stall and the exception request are combinational on the registered time, so they change in the very cycle in which time_now reaches the target. The bench drives an operation on the falling edge and then checks the outputs one time unit later. Those outputs reflect only the state before the coming rising edge. The bench then advances its own model across that edge, so every expected value is compared in exactly the cycle the requirements name.

// File: rtl/dtu_pkg.sv
// Shared definitions for the deadline timer unit.
// Assumes one operation is issued per cycle, with a 3-bit opcode.
package dtu_pkg;
    typedef enum logic [2:0] {
        OP_NONE   = 3'd0,
        OP_READ   = 3'd1,
        OP_WAIT   = 3'd2,
        OP_ARM    = 3'd3,
        OP_DISARM = 3'd4
    } dtu_op_e;
endpackage

// File: rtl/dtu_clock.sv
// Free-running time base: advances by STEP on every clock after reset.
// Assumes the counter width is large enough that wrap-around never matters.
module dtu_clock #(
    parameter int TIME_W = 64,
    parameter int STEP   = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    output logic [TIME_W-1:0] now
);
    localparam logic [TIME_W-1:0] INC = TIME_W'(STEP);

    // Advance time by one step per cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) now <= '0;
        else        now <= now + INC;
    end
endmodule

// File: rtl/dtu_wait_slot.sv
// Per-thread blocking wait. A start with a future target holds stall
// until the time base reaches the target; a target already reached is a no-op.
// Assumes the thread issues no new wait while it is stalled; if it does, the new target wins.
module dtu_wait_slot #(
    parameter int TIME_W = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [TIME_W-1:0] now,
    input  logic              start,
    input  logic [TIME_W-1:0] target,
    output logic              stall
);
    logic              waiting_q;
    logic [TIME_W-1:0] target_q;

    // Track the pending target and drop it once time has caught up.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            waiting_q <= 1'b0;
            target_q  <= '0;
        end else if (start) begin
            waiting_q <= (target > now);
            target_q  <= target;
        end else if (waiting_q && (now >= target_q)) begin
            waiting_q <= 1'b0;
        end
    end

    // Release in the same cycle that time reaches the target.
    always_comb stall = waiting_q && (now < target_q);
endmodule

// File: rtl/dtu_deadline_slot.sv
// Per-thread armed deadline. Fires a one-cycle request once time reaches
// the armed value, then disarms itself. Re-arming replaces the earlier deadline.
// Assumes a disarm in the firing cycle arrives too late to suppress that cycle.
module dtu_deadline_slot #(
    parameter int TIME_W = 64,
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [TIME_W-1:0] now,
    input  logic              arm,
    input  logic              disarm,
    input  logic [TIME_W-1:0] arm_ts,
    input  logic [ADDR_W-1:0] arm_addr,
    output logic              fire,
    output logic [ADDR_W-1:0] handler
);
    logic              armed_q;
    logic [TIME_W-1:0] ts_q;

    // Request while armed and the deadline has been reached.
    always_comb fire = armed_q && (now >= ts_q);

    // Record or clear the deadline; a fire clears it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            armed_q <= 1'b0;
            ts_q    <= '0;
            handler <= '0;
        end else if (arm) begin
            armed_q <= 1'b1;
            ts_q    <= arm_ts;
            handler <= arm_addr;
        end else if (disarm || fire) begin
            armed_q <= 1'b0;
        end
    end
endmodule

// File: rtl/deadline_timer_unit.sv
// Time-control unit for a multithreaded core: a shared time base, read
// capture, and per-thread wait and deadline slots selected by op_tid.
// Assumes at most one operation per cycle and that the timestamp is built from two register halves.
module deadline_timer_unit #(
    parameter int NUM_THREADS = 8,
    parameter int REG_W       = 32,
    parameter int ADDR_W      = 32,
    parameter int STEP        = 20,
    localparam int TIME_W     = 2 * REG_W,
    localparam int TID_W      = $clog2(NUM_THREADS)
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          op_valid,
    input  logic [2:0]                    op_code,
    input  logic [TID_W-1:0]              op_tid,
    input  logic [REG_W-1:0]              ts_hi,
    input  logic [REG_W-1:0]              ts_lo,
    input  logic [ADDR_W-1:0]             handler,
    output logic [TIME_W-1:0]             time_now,
    output logic [TIME_W-1:0]             rd_data,
    output logic [NUM_THREADS-1:0]        stall,
    output logic [NUM_THREADS-1:0]        exc_req,
    output logic [NUM_THREADS*ADDR_W-1:0] exc_addr
);
    import dtu_pkg::*;

    dtu_op_e           op;
    logic [TIME_W-1:0] ts;

    // Decode the opcode and join the timestamp halves.
    always_comb begin
        op = dtu_op_e'(op_code);
        ts = {ts_hi, ts_lo};
    end

    dtu_clock #(.TIME_W(TIME_W), .STEP(STEP)) u_clock (
        .clk   (clk),
        .rst_n (rst_n),
        .now   (time_now)
    );

    // Capture time on a read operation.
    always_ff @(posedge clk) begin
        if (!rst_n)                           rd_data <= '0;
        else if (op_valid && op == OP_READ)   rd_data <= time_now;
    end

    for (genvar t = 0; t < NUM_THREADS; t++) begin : g_thr
        logic sel;

        // Thread select for this slot pair.
        always_comb sel = op_valid && (op_tid == TID_W'(t));

        dtu_wait_slot #(.TIME_W(TIME_W)) u_wait (
            .clk    (clk),
            .rst_n  (rst_n),
            .now    (time_now),
            .start  (sel && op == OP_WAIT),
            .target (ts),
            .stall  (stall[t])
        );

        dtu_deadline_slot #(.TIME_W(TIME_W), .ADDR_W(ADDR_W)) u_dl (
            .clk      (clk),
            .rst_n    (rst_n),
            .now      (time_now),
            .arm      (sel && op == OP_ARM),
            .disarm   (sel && op == OP_DISARM),
            .arm_ts   (ts),
            .arm_addr (handler),
            .fire     (exc_req[t]),
            .handler  (exc_addr[t*ADDR_W +: ADDR_W])
        );
    end
endmodule

// File: rtl/dtu_checker.sv
// Port-level properties of the deadline timer unit, bound to the top.
// Assumes the default opcode values of the package.
module dtu_checker #(
    parameter int NUM_THREADS = 8,
    parameter int REG_W       = 32,
    parameter int STEP        = 20,
    localparam int TIME_W     = 2 * REG_W,
    localparam int TID_W      = $clog2(NUM_THREADS)
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   op_valid,
    input logic [2:0]             op_code,
    input logic [TID_W-1:0]       op_tid,
    input logic [REG_W-1:0]       ts_hi,
    input logic [REG_W-1:0]       ts_lo,
    input logic [TIME_W-1:0]      time_now,
    input logic [TIME_W-1:0]      rd_data,
    input logic [NUM_THREADS-1:0] stall,
    input logic [NUM_THREADS-1:0] exc_req
);
    logic warm;

    // Marks that one edge has passed since reset release.
    always_ff @(posedge clk) begin
        if (!rst_n) warm <= 1'b0;
        else        warm <= 1'b1;
    end

    p_step_r2: assert property (@(posedge clk) disable iff (!rst_n || !warm)
        time_now == $past(time_now) + TIME_W'(STEP));

    p_read_r3: assert property (@(posedge clk) disable iff (!rst_n || !warm)
        (op_valid && op_code == 3'd1) |=> (rd_data == $past(time_now)));

    for (genvar t = 0; t < NUM_THREADS; t++) begin : g_chk
        p_rise_r4: assert property (@(posedge clk) disable iff (!rst_n || !warm)
            $rose(stall[t]) |-> $past(op_valid && op_tid == TID_W'(t) && op_code == 3'd2));

        p_past_r5: assert property (@(posedge clk) disable iff (!rst_n || !warm)
            (op_valid && op_tid == TID_W'(t) && op_code == 3'd2 &&
             {ts_hi, ts_lo} <= time_now) |=> !stall[t]);

        p_arm_r6: assert property (@(posedge clk) disable iff (!rst_n || !warm)
            (op_valid && op_tid == TID_W'(t) && op_code == 3'd3 && !stall[t]) |=> !stall[t]);

        p_once_r7: assert property (@(posedge clk) disable iff (!rst_n || !warm)
            (exc_req[t] && !(op_valid && op_tid == TID_W'(t) && op_code == 3'd3))
            |=> !exc_req[t]);
    end
endmodule

bind deadline_timer_unit dtu_checker #(
    .NUM_THREADS (NUM_THREADS),
    .REG_W       (REG_W),
    .STEP        (STEP)
) i_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .op_valid (op_valid),
    .op_code  (op_code),
    .op_tid   (op_tid),
    .ts_hi    (ts_hi),
    .ts_lo    (ts_lo),
    .time_now (time_now),
    .rd_data  (rd_data),
    .stall    (stall),
    .exc_req  (exc_req)
);

// File: tb/test_deadline_timer_unit.sv
module test_deadline_timer_unit;
    localparam int NT = 8;
    localparam logic [2:0] C_NONE = 3'd0, C_READ = 3'd1, C_WAIT = 3'd2,
                           C_ARM = 3'd3, C_DIS = 3'd4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic op_valid = 1'b0;
    logic [2:0] op_code = '0;
    logic [2:0] op_tid = '0;
    logic [31:0] ts_hi = '0, ts_lo = '0, handler = '0;
    logic [63:0] time_now, rd_data;
    logic [NT-1:0] stall, exc_req;
    logic [NT*32-1:0] exc_addr;

    int vectors = 0, miscompares = 0;
    bit finished = 0;

    // bench model
    logic [63:0] m_now = '0, m_rd = '0;
    logic [NT-1:0] m_wait = '0, m_armed = '0;
    logic [63:0] m_tgt [NT];
    logic [63:0] m_dts [NT];
    logic [31:0] m_dadr [NT];

    always #2 clk = ~clk;

    deadline_timer_unit i_deadline_timer_unit (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
        .op_tid(op_tid), .ts_hi(ts_hi), .ts_lo(ts_lo), .handler(handler),
        .time_now(time_now), .rd_data(rd_data), .stall(stall),
        .exc_req(exc_req), .exc_addr(exc_addr)
    );

    function automatic logic [NT-1:0] exp_stall();
        logic [NT-1:0] s;
        for (int t = 0; t < NT; t++) s[t] = m_wait[t] && (m_now < m_tgt[t]);
        return s;
    endfunction

    function automatic logic [NT-1:0] exp_fire();
        logic [NT-1:0] f;
        for (int t = 0; t < NT; t++) f[t] = m_armed[t] && (m_now >= m_dts[t]);
        return f;
    endfunction

    // compare all outputs against the model for the current cycle
    task automatic check_cycle();
        logic [NT-1:0] es, ef;
        bit bad;
        es = exp_stall();
        ef = exp_fire();
        bad = 0;
        vectors++;
        if (time_now !== m_now) begin
            $display("FAIL R2 time_now actual %0d expected %0d", time_now, m_now); bad = 1;
        end
        if (rd_data !== m_rd) begin
            $display("FAIL R3 rd_data actual %0d expected %0d", rd_data, m_rd); bad = 1;
        end
        if (stall !== es) begin
            $display("FAIL R4/R5 stall actual %b expected %b", stall, es); bad = 1;
        end
        if (exc_req !== ef) begin
            $display("FAIL R7 exc_req actual %b expected %b", exc_req, ef); bad = 1;
        end
        for (int t = 0; t < NT; t++)
            if (ef[t] && exc_addr[t*32 +: 32] !== m_dadr[t]) begin
                $display("FAIL R7 exc_addr[%0d] actual %h expected %h",
                         t, exc_addr[t*32 +: 32], m_dadr[t]);
                bad = 1;
            end
        if (bad) miscompares++;
    endtask

    // advance the model across one rising edge
    task automatic model_edge();
        logic [NT-1:0] ef;
        logic [63:0] ts;
        ef = exp_fire();
        ts = {ts_hi, ts_lo};
        for (int t = 0; t < NT; t++) begin
            bit sel;
            sel = op_valid && (op_tid == 3'(t));
            if (sel && op_code == C_WAIT) begin
                m_wait[t] = (ts > m_now);
                m_tgt[t] = ts;
            end else if (m_wait[t] && m_now >= m_tgt[t]) m_wait[t] = 0;
            if (sel && op_code == C_ARM) begin
                m_armed[t] = 1; m_dts[t] = ts; m_dadr[t] = handler;
            end else if ((sel && op_code == C_DIS) || ef[t]) m_armed[t] = 0;
        end
        if (op_valid && op_code == C_READ) m_rd = m_now;
        m_now = m_now + 64'd20;
    endtask

    // one full cycle: drive at falling edge, check, cross the rising edge
    task automatic cyc(input bit v, input logic [2:0] c, input logic [2:0] tid,
                       input logic [63:0] ts, input logic [31:0] h);
        @(negedge clk);
        op_valid = v; op_code = c; op_tid = tid;
        {ts_hi, ts_lo} = ts; handler = h;
        #1;
        check_cycle();
        @(posedge clk);
        model_edge();
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) cyc(0, C_NONE, 0, 64'd0, 32'd0);
    endtask

    initial begin
        for (int t = 0; t < NT; t++) begin
            m_tgt[t] = '0; m_dts[t] = '0; m_dadr[t] = '0;
        end
        void'($urandom(32'd5150));
        repeat (3) @(posedge clk);
        // R1: reset state
        @(negedge clk);
        vectors++;
        if (time_now !== 0 || rd_data !== 0 || stall !== 0 || exc_req !== 0) begin
            miscompares++;
            $display("FAIL R1 reset outputs actual %0d/%0d/%b/%b expected 0/0/0/0",
                     time_now, rd_data, stall, exc_req);
        end
        rst_n = 1'b1;
        @(posedge clk);
        model_edge();

        // R1, R2: first cycles after release
        idle(2);
        // R5: wait on the current time is not a stall
        cyc(1, C_WAIT, 0, m_now, 0); idle(2);
        // R4: target between steps, released by greater-or-equal
        cyc(1, C_WAIT, 1, m_now + 30, 0); idle(3);
        // R4: target two steps ahead
        cyc(1, C_WAIT, 2, m_now + 40, 0); idle(3);
        // R6, R7, R8: deadline already reached fires once next cycle, then stays quiet
        cyc(1, C_ARM, 3, m_now, 32'hA000_0003); idle(4);
        // R9: disarm before firing suppresses the request
        cyc(1, C_ARM, 4, m_now + 100, 32'hA000_0004);
        cyc(1, C_DIS, 4, 0, 0); idle(8);
        // R10: re-arm replaces timestamp and handler
        cyc(1, C_ARM, 5, m_now + 200, 32'hA000_0005);
        cyc(1, C_ARM, 5, m_now + 60, 32'hB000_0005); idle(14);
        // R9: disarm in the firing cycle still sees the request
        cyc(1, C_ARM, 6, m_now + 40, 32'hA000_0006);
        idle(1);
        cyc(1, C_DIS, 6, 0, 0); idle(2);
        // R11: op_valid low and opcode none do nothing
        cyc(0, C_WAIT, 7, m_now + 400, 0);
        cyc(1, C_NONE, 7, m_now + 400, 0); idle(2);
        // R3: read captures time
        cyc(1, C_READ, 0, 0, 0); idle(1);
        cyc(1, C_READ, 3, 0, 0); idle(1);

        // random mix across threads (R3..R11)
        for (int i = 0; i < 4000; i++) begin
            logic [2:0] c;
            logic [63:0] ts;
            int off;
            c = 3'($urandom_range(0, 4));
            off = int'($urandom_range(0, 360)) - 60;
            if (off < 0 && m_now < 64'(-off)) ts = 0;
            else ts = m_now + 64'(signed'(off));
            cyc(($urandom_range(0, 3) != 0), c, 3'($urandom_range(0, 7)), ts, $urandom());
        end
        idle(30);

        if (!finished) begin
            finished = 1;
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            miscompares++;
            $display("FAIL watchdog expired actual running expected done");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end
endmodule